// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This combinational block sits in front of a single-precision fused multiply-add datapath computing z + (x * y), or z - (x * y) when the negate-product control is high. It sorts each of the three IEEE-754 operands into one of six classes: signalling NaN, quiet NaN, infinity, zero, denormal or normal. It then decides whether those classes alone fix the final answer.

When they do, the block drives the finished 32-bit result and the invalid-operation flag. When they do not, it raises `proceed`, so the arithmetic pipeline does the real work. It always drives the effective product sign, and it drives a mask of denormal operands so the pipeline knows which inputs to normalise.

The rounding mode arrives on two bits: 00 nearest-even, 01 toward zero, 10 toward +inf, 11 toward -inf. Only toward -inf changes this block's output.

Top module: `fmaSpecialResolver`

## Requirements
- R1: `denormMask` has bit 2 for z, bit 1 for x and bit 0 for y. A bit is 1 exactly when that operand has exponent field 0 and a nonzero fraction.
- R2: An operand with exponent 0xFF, fraction bit 22 clear and a nonzero fraction is signalling. If any operand is signalling, the first signalling one in the order z, x, y is returned with fraction bit 22 set, and `invalidOp` is 1. A signalling NaN wins over any quiet NaN.
- R3: An operand with exponent 0xFF and fraction bit 22 set is quiet. With no signalling NaN present, the first quiet NaN in the order z, x, y is returned unchanged, and `invalidOp` is 0.
- R4: `prodSign` always equals bit 31 of x XOR bit 31 of y XOR `negProd`.
- R5: With no NaN present, if one multiplicand is infinite and the other is zero, `result` is 0x7FC00000 and `invalidOp` is 1.
- R6: With no NaN present and an infinite product, if z is infinite with a sign different from `prodSign`, `result` is 0x7FC00000 and `invalidOp` is 1. Otherwise `result` is infinity carrying `prodSign`.
- R7: With no NaN present, a finite product and an infinite z, `result` is z.
- R8: With no NaN present, a zero product and a nonzero finite z, `result` is z.
- R9: With a zero product and a zero z, `result` is z if z's sign equals `prodSign`. Otherwise `result` is +0, or -0 when `rndMode` is 2'b11.
- R10: `proceed` is 1 exactly when no NaN or infinity is present and neither multiplicand is zero. In that case `result` is 0 and `invalidOp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opZ | input | 32 | Addend |
| opX | input | 32 | First multiplicand |
| opY | input | 32 | Second multiplicand |
| negProd | input | 1 | Negate the product before the add |
| rndMode | input | 2 | Rounding mode; 2'b11 is toward -inf |
| result | output | 32 | Final value when a special case applies, otherwise 0 |
| invalidOp | output | 1 | Invalid-operation exception |
| proceed | output | 1 | No special case applies; the datapath must compute |
| prodSign | output | 1 | Effective sign of the product |
| denormMask | output | 3 | Denormal flags for z, x and y |

## Verification
Several special cases can apply to the same operand set, and the block must pick the one with the highest precedence. Examples are a signalling NaN in y together with a quiet NaN in z, an infinity-times-zero product alongside an opposite infinite z, and a negated zero product against a zero z under round-down.

The bench builds such collisions on purpose by drawing each operand's class at random, so that NaNs, infinities and zeros often share one vector. Directed vectors cover the sign and precedence boundaries. Every output is compared against a bench reference function that walks the precedence order.

// File: rtl/fmaPkg.sv
package fmaPkg;
  localparam int WORD_W    = 32;
  localparam int EXP_W     = 8;
  localparam int FRAC_W    = 23;
  localparam int QUIET_BIT = FRAC_W - 1;
  localparam int NUM_OPS   = 3;
  localparam logic [1:0] RND_DOWN = 2'b11;
  localparam logic [WORD_W-1:0] DEFAULT_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  // operand indices inside the packed operand vector
  localparam int IDX_Z = 2;
  localparam int IDX_X = 1;
  localparam int IDX_Y = 0;

  typedef enum logic [2:0] {
    CL_ZERO, CL_DENORM, CL_NORMAL, CL_INF, CL_QNAN, CL_SNAN
  } opClass_e;

  typedef enum logic [2:0] {
    RK_PROCEED, RK_PASS, RK_QUIET, RK_DEFNAN, RK_INF, RK_ZERO
  } resKind_e;

  typedef struct packed {
    resKind_e   kind;
    logic [1:0] srcSel;
    logic       raiseInv;
    logic       outSign;
  } strobe_t;
endpackage

// File: rtl/fmaClassifier.sv
module fmaClassifier
  import fmaPkg::*;
#(
  parameter int EXP_BITS  = EXP_W,
  parameter int FRAC_BITS = FRAC_W
) (
  input  logic [EXP_BITS+FRAC_BITS:0] opIn,
  output opClass_e                    opClass
);
  localparam int QB = FRAC_BITS - 1;

  logic [EXP_BITS-1:0]  expField;
  logic [FRAC_BITS-1:0] fracField;
  logic expAllOnes, expAllZero, fracZero;

  assign expField   = opIn[EXP_BITS+FRAC_BITS-1:FRAC_BITS];
  assign fracField  = opIn[FRAC_BITS-1:0];
  assign expAllOnes = &expField;
  assign expAllZero = ~|expField;
  assign fracZero   = ~|fracField;

  always_comb begin
    if (expAllOnes) begin
      if (fracZero)            opClass = CL_INF;
      else if (fracField[QB])  opClass = CL_QNAN;
      else                     opClass = CL_SNAN;
    end else if (expAllZero) begin
      opClass = fracZero ? CL_ZERO : CL_DENORM;
    end else begin
      opClass = CL_NORMAL;
    end
  end
endmodule

// File: rtl/fmaSpecialCtrl.sv
module fmaSpecialCtrl
  import fmaPkg::*;
(
  input  opClass_e   zCls,
  input  opClass_e   xCls,
  input  opClass_e   yCls,
  input  logic       zSign,
  input  logic       xSign,
  input  logic       ySign,
  input  logic       negProd,
  input  logic [1:0] rndMode,
  output strobe_t    strobe,
  output logic       prodSign
);
  logic anySnan, anyQnan, prodInf, prodZero, infTimesZero;
  logic [1:0] snanSrc, qnanSrc;

  assign prodSign     = xSign ^ ySign ^ negProd;
  assign anySnan      = (zCls == CL_SNAN) || (xCls == CL_SNAN) || (yCls == CL_SNAN);
  assign anyQnan      = (zCls == CL_QNAN) || (xCls == CL_QNAN) || (yCls == CL_QNAN);
  assign prodInf      = (xCls == CL_INF) || (yCls == CL_INF);
  assign prodZero     = (xCls == CL_ZERO) || (yCls == CL_ZERO);
  assign infTimesZero = prodInf && prodZero;

  // fixed z-x-y precedence within each NaN kind
  always_comb begin
    if (zCls == CL_SNAN)      snanSrc = 2'(IDX_Z);
    else if (xCls == CL_SNAN) snanSrc = 2'(IDX_X);
    else                      snanSrc = 2'(IDX_Y);
    if (zCls == CL_QNAN)      qnanSrc = 2'(IDX_Z);
    else if (xCls == CL_QNAN) qnanSrc = 2'(IDX_X);
    else                      qnanSrc = 2'(IDX_Y);
  end

  always_comb begin
    strobe = '{kind: RK_PROCEED, srcSel: 2'(IDX_Z), raiseInv: 1'b0, outSign: 1'b0};
    if (anySnan) begin
      strobe.kind     = RK_QUIET;
      strobe.srcSel   = snanSrc;
      strobe.raiseInv = 1'b1;
    end else if (anyQnan) begin
      strobe.kind   = RK_PASS;
      strobe.srcSel = qnanSrc;
    end else if (infTimesZero) begin
      strobe.kind     = RK_DEFNAN;
      strobe.raiseInv = 1'b1;
    end else if (prodInf) begin
      if (zCls == CL_INF && zSign != prodSign) begin
        strobe.kind     = RK_DEFNAN;
        strobe.raiseInv = 1'b1;
      end else begin
        strobe.kind    = RK_INF;
        strobe.outSign = prodSign;
      end
    end else if (zCls == CL_INF) begin
      strobe.kind = RK_PASS;
    end else if (prodZero) begin
      if (zCls == CL_ZERO && zSign != prodSign) begin
        strobe.kind    = RK_ZERO;
        strobe.outSign = (rndMode == RND_DOWN);
      end else begin
        strobe.kind = RK_PASS;
      end
    end
  end

  always_comb begin
    if (!$isunknown({zCls, xCls, yCls})) begin
      // R2
      snan_first_chk: assert (!(anySnan && anyQnan) || strobe.kind == RK_QUIET);
      // R5
      inf_zero_chk: assert (!infTimesZero || anySnan || anyQnan || strobe.kind == RK_DEFNAN);
    end
  end
endmodule

// File: rtl/fmaSpecialData.sv
module fmaSpecialData
  import fmaPkg::*;
(
  input  logic [NUM_OPS-1:0][WORD_W-1:0] ops,
  input  strobe_t                        strobe,
  output logic [WORD_W-1:0]              result,
  output logic                           invalidOp,
  output logic                           proceed
);
  logic [WORD_W-1:0] srcWord;

  assign srcWord = ops[strobe.srcSel];

  always_comb begin
    result = '0;
    unique case (strobe.kind)
      RK_PASS:    result = srcWord;
      RK_QUIET:   result = srcWord | (WORD_W'(1) << QUIET_BIT);
      RK_DEFNAN:  result = DEFAULT_NAN;
      RK_INF:     result = {strobe.outSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      RK_ZERO:    result = {strobe.outSign, {(WORD_W-1){1'b0}}};
      default:    result = '0;
    endcase
  end

  assign invalidOp = strobe.raiseInv;
  assign proceed   = (strobe.kind == RK_PROCEED);

  always_comb begin
    if (!$isunknown({ops, strobe})) begin
      // R5
      inv_is_nan_chk: assert (!invalidOp || (&result[WORD_W-2:FRAC_W] && result[QUIET_BIT]));
      // R10
      proceed_quiet_chk: assert (!proceed || (!invalidOp && result == '0));
    end
  end
endmodule

// File: rtl/fmaSpecialResolver.sv
module fmaSpecialResolver
  import fmaPkg::*;
(
  input  logic [31:0] opZ,
  input  logic [31:0] opX,
  input  logic [31:0] opY,
  input  logic        negProd,
  input  logic [1:0]  rndMode,
  output logic [31:0] result,
  output logic        invalidOp,
  output logic        proceed,
  output logic        prodSign,
  output logic [2:0]  denormMask
);
  logic [NUM_OPS-1:0][WORD_W-1:0] ops;
  opClass_e cls [NUM_OPS];
  strobe_t  strobe;

  assign ops = {opZ, opX, opY};

  for (genvar i = 0; i < NUM_OPS; i++) begin : g_cls
    fmaClassifier #(.EXP_BITS(EXP_W), .FRAC_BITS(FRAC_W)) u_cls (
      .opIn(ops[i]), .opClass(cls[i]));
    assign denormMask[i] = (cls[i] == CL_DENORM);
  end

  fmaSpecialCtrl u_ctrl (
    .zCls(cls[IDX_Z]), .xCls(cls[IDX_X]), .yCls(cls[IDX_Y]),
    .zSign(opZ[WORD_W-1]), .xSign(opX[WORD_W-1]), .ySign(opY[WORD_W-1]),
    .negProd(negProd), .rndMode(rndMode),
    .strobe(strobe), .prodSign(prodSign));

  fmaSpecialData u_data (
    .ops(ops), .strobe(strobe),
    .result(result), .invalidOp(invalidOp), .proceed(proceed));

  always_comb begin
    if (!$isunknown({opZ, opX, opY, negProd})) begin
      // R4
      prod_sign_chk: assert (prodSign == (opX[31] ^ opY[31] ^ negProd));
      // R1
      denorm_flag_chk: assert (!denormMask[IDX_Z] || (opZ[30:23] == 8'h00 && opZ[22:0] != 0));
      // R10
      proceed_finite_chk: assert (!proceed || (opZ[30:23] != 8'hFF && opX[30:23] != 8'hFF
                                               && opY[30:23] != 8'hFF));
    end
  end
endmodule

// File: tb/fmaSpecialResolver_test.sv
module fmaSpecialResolver_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] opZ = '0, opX = '0, opY = '0;
  logic        negProd = 1'b0;
  logic [1:0]  rndMode = 2'b00;
  logic [31:0] result;
  logic        invalidOp, proceed, prodSign;
  logic [2:0]  denormMask;
  int vectors = 0, miscompares = 0;
  bit done = 0;

  fmaSpecialResolver uut (.*);

  localparam logic [31:0] DNAN = 32'h7FC00000;

  function automatic bit isSn(logic [31:0] v); return v[30:23] == 8'hFF && !v[22] && v[21:0] != 0; endfunction
  function automatic bit isQn(logic [31:0] v); return v[30:23] == 8'hFF && v[22]; endfunction
  function automatic bit isIn(logic [31:0] v); return v[30:0] == 31'h7F800000; endfunction
  function automatic bit isZe(logic [31:0] v); return v[30:0] == 0; endfunction
  function automatic bit isDn(logic [31:0] v); return v[30:23] == 0 && v[22:0] != 0; endfunction

  // expected {result, invalid, proceed, prodSign, denormMask}
  function automatic logic [37:0] refModel(logic [31:0] z, x, y, logic ng, logic [1:0] rm,
                                           output string tag);
    logic ps = x[31] ^ y[31] ^ ng;
    logic [2:0] dm = {isDn(z), isDn(x), isDn(y)};
    logic [31:0] r = 0; logic inv = 0, pr = 0;
    if (isSn(z) || isSn(x) || isSn(y)) begin
      tag = "R2"; inv = 1;
      r = isSn(z) ? z : (isSn(x) ? x : y);
      r[22] = 1'b1;
    end else if (isQn(z) || isQn(x) || isQn(y)) begin
      tag = "R3"; r = isQn(z) ? z : (isQn(x) ? x : y);
    end else if ((isIn(x) && isZe(y)) || (isZe(x) && isIn(y))) begin
      tag = "R5"; r = DNAN; inv = 1;
    end else if (isIn(x) || isIn(y)) begin
      tag = "R6";
      if (isIn(z) && z[31] != ps) begin r = DNAN; inv = 1; end
      else r = {ps, 31'h7F800000};
    end else if (isIn(z)) begin
      tag = "R7"; r = z;
    end else if (isZe(x) || isZe(y)) begin
      if (!isZe(z)) begin tag = "R8"; r = z; end
      else begin
        tag = "R9";
        r = (z[31] == ps) ? z : {(rm == 2'b11), 31'h0};
      end
    end else begin
      tag = "R10"; pr = 1;
    end
    return {r, inv, pr, ps, dm};
  endfunction

  function automatic logic [31:0] mkOp(int cls, logic s);
    logic [22:0] f = 23'($urandom());
    case (cls)
      0: return {s, 31'h0};
      1: return {s, 8'h00, (f == 0) ? 23'h1 : f};
      2: return {s, 8'(1 + $urandom_range(0, 253)), f};
      3: return {s, 8'hFF, 23'h0};
      4: return {s, 8'hFF, 1'b1, f[21:0]};
      default: return {s, 8'hFF, 1'b0, (f[21:0] == 0) ? 22'h1 : f[21:0]};
    endcase
  endfunction

  task automatic apply(logic [31:0] z, x, y, logic ng, logic [1:0] rm);
    logic [37:0] exp, act; string tag;
    @(posedge clk);
    opZ = z; opX = x; opY = y; negProd = ng; rndMode = rm;
    @(negedge clk);
    exp = refModel(z, x, y, ng, rm, tag);
    act = {result, invalidOp, proceed, prodSign, denormMask};
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (R4 sign, R1 mask incl.) z=%h x=%h y=%h ng=%b rm=%b actual=%h expected=%h",
               tag, z, x, y, ng, rm, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // initial state: all-zero inputs, R9 same-sign zero sum
    apply(32'h0, 32'h0, 32'h0, 0, 2'b00);
    // R2: sNaN in y outranks qNaN in z
    apply(32'h7FC00001, 32'h3F800000, 32'h7F800005, 0, 2'b00);
    // R2: z sNaN beats x sNaN
    apply(32'hFF800010, 32'h7F800001, 32'h0, 1, 2'b00);
    // R3: x qNaN before y qNaN, unchanged payload
    apply(32'h3F800000, 32'hFFC12345, 32'h7FC00001, 0, 2'b00);
    // R5: inf * 0 with opposite infinite z
    apply(32'hFF800000, 32'h7F800000, 32'h80000000, 0, 2'b00);
    // R6: opposite-sign infinities, both negProd settings
    apply(32'hFF800000, 32'h7F800000, 32'h3F800000, 0, 2'b00);
    apply(32'hFF800000, 32'h7F800000, 32'h3F800000, 1, 2'b00);
    apply(32'h3F800000, 32'h7F800000, 32'h00000001, 1, 2'b00);
    // R7: finite product, infinite z
    apply(32'hFF800000, 32'h3F800000, 32'h00400000, 0, 2'b00);
    // R8: zero product, nonzero z
    apply(32'h00000003, 32'h80000000, 32'h40000000, 1, 2'b11);
    // R9: opposite-sign zeros, all rounding modes
    for (int m = 0; m < 4; m++) apply(32'h80000000, 32'h0, 32'h3F800000, 0, 2'(m));
    apply(32'h00000000, 32'h0, 32'h3F800000, 1, 2'b11);
    // R10, R1: proceed with denormal operands
    apply(32'h00000001, 32'h00700000, 32'hBF800000, 1, 2'b01);
    // random class mixes
    for (int i = 0; i < 4000; i++)
      apply(mkOp($urandom_range(0, 5), 1'($urandom())), mkOp($urandom_range(0, 5), 1'($urandom())),
            mkOp($urandom_range(0, 5), 1'($urandom())), 1'($urandom()), 2'($urandom()));
    done = 1;
    finishRun();
  end
endmodule